// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital front-end of a single-shot successive-approximation converter with up to eight multiplexed inputs. Software reaches it over a plain word-wide register bus. A write to the control register picks an input, enables the interrupt and switches power on. The block then waits a programmed number of converter clocks so the analog section can settle. It resolves the result one bit per clock against an external comparator and stores the code. Finally it flags completion and can raise an interrupt line. A single write of zero to control clears the flag, powers the converter down and abandons any conversion still in flight. Software uses that write both as the normal completion handshake and as the recovery path after a timeout.

In this block the converter clock and the bus clock are the same clock. The bus uses word addresses: 0 is result, 1 is status, 2 is control and 3 is the settle delay. In byte terms these are offsets 0x00, 0x04, 0x08 and 0x0C. The trial code goes out on `trial_code`, and the comparator answers on `cmp_ge`. The selected input goes out on `mux_sel`.

The sequencer has four states: OFF (unpowered), SETTLE (counting the delay), RESOLVE (approximating) and HOLD (powered, result ready). Its transitions are:
- power-on: OFF to SETTLE when the delay is non-zero, or OFF straight to RESOLVE when the delay is zero.
- settle-done: SETTLE to RESOLVE.
- last-bit: RESOLVE to HOLD.
- power-off: any state to OFF.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset every register reads 0, the status busy bit is 0, `pwr_on` is 0 and `irq` is 0.
- R2: The delay register (word 3) keeps only its low 6 bits. The control register (word 2) reads back as follows: input select in bits 2:0, power in bit 3, interrupt enable in bit 5, pending flag in bit 6. All other bits read 0.
- R3: A conversion starts only on a control write that takes the power bit from 0 to 1. Status bit 0 reads 1 from the cycle after that write until the result is stored, and it is never 1 while power is off.
- R4: With delay D, busy stays high for exactly D + RES_W clock cycles. D = 0 starts the first trial immediately.
- R5: Trials run MSB first at one clock per bit. The first trial code has only the MSB set. A trial bit is kept when `cmp_ge` is 1, so the stored result equals the largest code at or below the input.
- R6: At the end of a conversion the result register holds the code with zero upper bits, busy clears, and the pending flag (bit 6) sets.
- R7: `irq` is 1 exactly when the pending flag and the interrupt-enable bit are both 1.
- R8: A control write with bit 3 = 0 powers down and aborts at once. Busy falls the next cycle, and the result register keeps its previous value. Writing 0 also clears the pending flag, so `irq` falls.
- R9: Writing the power bit as 1 while it is already 1 does not start a new conversion, either during a conversion or after it.
- R10: `mux_sel` takes the input select at the power-on write and holds it until the conversion ends, even if control is rewritten in between.
- R11: A control write with bit 6 = 0 clears the pending flag. Writing bit 6 = 1 leaves the flag unchanged and cannot set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | 2 | Word address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr` (combinational) |
| cmp_ge | input | 1 | Comparator: input is at or above `trial_code` |
| trial_code | output | RES_W | Code driven into the DAC |
| mux_sel | output | 3 | Held input select |
| pwr_on | output | 1 | Converter power enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures busy length for delays of 0, 1, 63 and random values. A miscounted settle window or an extra trial shows up there as a cycle count off by one. It converts full-scale, zero and mid-scale inputs, where a wrong compare polarity or an LSB-first order would store a wrong code. It rewrites control mid-conversion and after completion with power still set, and it aborts mid-conversion. A design that restarted on those writes, switched the mux, or let an aborted run update the result or pending flag would show a changed busy count, `mux_sel` or data word.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_RESOLVE = 2'd2,
        ST_HOLD    = 2'd3
    } sar_state_e;

    // word addresses on the register bus
    localparam logic [1:0] WA_RESULT = 2'd0;
    localparam logic [1:0] WA_STATUS = 2'd1;
    localparam logic [1:0] WA_CTRL   = 2'd2;
    localparam logic [1:0] WA_DELAY  = 2'd3;

    // control register bit positions
    localparam int unsigned CB_PWR  = 3;
    localparam int unsigned CB_IE   = 5;
    localparam int unsigned CB_PEND = 6;

endpackage

// File: rtl/sar_settle_cnt.sv
module sar_settle_cnt #(
    parameter int unsigned DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             dec,
    output logic             hit
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // last settle cycle: one count left
    assign hit = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             cmp_ge,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] res_next,
    output logic             last
);
    localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

    logic [RES_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= IDX_TOP;
        end else if (clr) begin
            acc_q <= '0;
            idx_q <= IDX_TOP;
        end else if (step) begin
            acc_q <= res_next;
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    always_comb begin
        trial    = acc_q | (RES_W'(1) << idx_q);
        res_next = cmp_ge ? trial : acc_q;
        last     = (idx_q == '0);
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       dly_zero,
    input  logic       dly_hit,
    input  logic       bit_last,
    output sar_state_e state,
    output logic       busy,
    output logic       cnt_load,
    output logic       cnt_dec,
    output logic       sar_clr,
    output logic       sar_step,
    output logic       done
);
    sar_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (start) begin
                    state_d = dly_zero ? ST_RESOLVE : ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (stop) begin
                    state_d = ST_OFF;
                end else if (dly_hit) begin
                    state_d = ST_RESOLVE;
                end
            end
            ST_RESOLVE: begin
                if (stop) begin
                    state_d = ST_OFF;
                end else if (bit_last) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (stop) begin
                    state_d = ST_OFF;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy     = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        sar_clr  = 1'b0;
        sar_step = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_load = start;
                sar_clr  = start;
            end
            ST_SETTLE: begin
                busy    = 1'b1;
                cnt_dec = 1'b1;
            end
            ST_RESOLVE: begin
                busy     = 1'b1;
                sar_step = 1'b1;
                done     = bit_last && !stop;
            end
            ST_HOLD: begin
                busy = 1'b0;
            end
            default: busy = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned CHAN_W = 3,
    parameter int unsigned DLY_W  = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_ge,
    output logic [RES_W-1:0]  trial_code,
    output logic [CHAN_W-1:0] mux_sel,
    output logic              pwr_on,
    output logic              irq
);
    localparam int unsigned PAD_RES = DATA_W - RES_W;
    localparam int unsigned PAD_DLY = DATA_W - DLY_W;

    logic [CHAN_W-1:0] chan_q;
    logic [CHAN_W-1:0] chan_hold_q;
    logic              pwr_q;
    logic              ie_q;
    logic              pend_q;
    logic [DLY_W-1:0]  dly_q;
    logic [RES_W-1:0]  result_q;

    logic wr_ctrl, wr_dly, start, stop;
    logic busy, cnt_load, cnt_dec, sar_clr, sar_step, done;
    logic dly_hit, bit_last;
    logic [RES_W-1:0] res_next;
    sar_state_e state;

    logic wdata_unused;
    assign wdata_unused = ^{bus_wdata[DATA_W-1:CB_PEND+1], bus_wdata[4]};

    assign wr_ctrl = bus_wr && (bus_waddr == WA_CTRL);
    assign wr_dly  = bus_wr && (bus_waddr == WA_DELAY);
    assign start   = wr_ctrl && bus_wdata[CB_PWR] && !pwr_q;
    assign stop    = wr_ctrl && !bus_wdata[CB_PWR];

    sar_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .stop     (stop),
        .dly_zero (dly_q == '0),
        .dly_hit  (dly_hit),
        .bit_last (bit_last),
        .state    (state),
        .busy     (busy),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .sar_clr  (sar_clr),
        .sar_step (sar_step),
        .done     (done)
    );

    sar_settle_cnt #(.DLY_W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (dly_q),
        .dec      (cnt_dec),
        .hit      (dly_hit)
    );

    sar_approx #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sar_clr),
        .step     (sar_step),
        .cmp_ge   (cmp_ge),
        .trial    (trial_code),
        .res_next (res_next),
        .last     (bit_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q      <= '0;
            chan_hold_q <= '0;
            pwr_q       <= 1'b0;
            ie_q        <= 1'b0;
            pend_q      <= 1'b0;
            dly_q       <= '0;
            result_q    <= '0;
        end else begin
            if (wr_dly) begin
                dly_q <= bus_wdata[DLY_W-1:0];
            end
            if (wr_ctrl) begin
                chan_q <= bus_wdata[CHAN_W-1:0];
                pwr_q  <= bus_wdata[CB_PWR];
                ie_q   <= bus_wdata[CB_IE];
            end
            if (start) begin
                chan_hold_q <= bus_wdata[CHAN_W-1:0];
            end
            if (done) begin
                result_q <= res_next;
            end
            // clear by write wins over a same-cycle completion
            if (wr_ctrl && !bus_wdata[CB_PEND]) begin
                pend_q <= 1'b0;
            end else if (done) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_waddr)
            WA_RESULT: bus_rdata = {{PAD_RES{1'b0}}, result_q};
            WA_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, busy};
            WA_CTRL: begin
                bus_rdata[CHAN_W-1:0] = chan_q;
                bus_rdata[CB_PWR]     = pwr_q;
                bus_rdata[CB_IE]      = ie_q;
                bus_rdata[CB_PEND]    = pend_q;
            end
            WA_DELAY:  bus_rdata = {{PAD_DLY{1'b0}}, dly_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign mux_sel = chan_hold_q;
    assign pwr_on  = pwr_q;
    assign irq     = pend_q & ie_q;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned CHAN_W = 3,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_waddr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic              pend,
    input logic [CHAN_W-1:0] mux_sel,
    input logic              pwr_on,
    input logic              irq,
    input logic [RES_W-1:0]  trial_code,
    input sar_state_e        state
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_waddr == WA_CTRL);

    p_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> !busy);

    p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RESOLVE) |-> trial_code == (RES_W'(1) << (RES_W - 1)));

    p_pend_from_resolve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(state) == ST_RESOLVE);

    p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend);

    p_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == '0) |=> (!busy && !irq && !pwr_on));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CB_PWR] && pwr_on && !busy) |=> !busy);

    p_chan_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .RES_W  (RES_W),
    .CHAN_W (CHAN_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_waddr  (bus_waddr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .pend       (pend_q),
    .mux_sel    (mux_sel),
    .pwr_on     (pwr_on),
    .irq        (irq),
    .trial_code (trial_code),
    .state      (state)
);

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
    localparam int RES = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_waddr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [RES-1:0] trial_code;
    logic [RES-1:0] vin = '0;
    logic        cmp_ge;
    logic [2:0]  mux_sel;
    logic        pwr_on, irq;

    int checks = 0;
    int errors = 0;
    int chan_bad = 0;

    always #10 clk = ~clk;

    // analog model: comparator against the input level
    assign cmp_ge = (vin >= trial_code);

    sar_conv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_ge(cmp_ge),
        .trial_code(trial_code), .mux_sel(mux_sel), .pwr_on(pwr_on), .irq(irq)
    );

    function automatic logic [31:0] ctrl_word(input logic [2:0] ch, input logic pwr,
                                              input logic ie, input logic pend);
        return {25'd0, pend, ie, 1'b0, pwr, ch};
    endfunction

    function automatic int busy_len(input int d);
        return d + RES;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_waddr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_waddr = a;
        #1;
        d = bus_rdata;
    endtask

    // counts busy cycles from the cycle after a power-on write; optional write at cycle wr_at
    task automatic run(input int wr_at, input logic [31:0] wd, input logic [2:0] ch,
                       output int cyc);
        cyc = 0;
        chan_bad = 0;
        forever begin
            bus_waddr = 2'd1;
            #1;
            if (!bus_rdata[0]) break;
            cyc++;
            if (mux_sel != ch) chan_bad++;
            if (cyc == wr_at) begin
                bus_waddr = 2'd2; bus_wdata = wd; bus_wr = 1'b1;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
            if (cyc > 300) break;
        end
        bus_wr = 1'b0;
    endtask

    task automatic convert(input logic [2:0] ch, input logic ie, input logic [RES-1:0] v,
                           input int d, input string tag);
        int cyc;
        logic [31:0] r;
        vin = v;
        wr(2'd3, d);
        wr(2'd2, ctrl_word(ch, 1'b1, ie, 1'b0));
        run(-1, '0, ch, cyc);
        chk(cyc == busy_len(d), {tag, " R4 busy length"}, cyc, busy_len(d));
        chk(chan_bad == 0, {tag, " R10 mux held"}, chan_bad, 0);
        rd(2'd0, r);
        chk(r == {22'd0, v}, {tag, " R5 R6 result"}, r, v);
        rd(2'd2, r);
        chk(r == ctrl_word(ch, 1'b1, ie, 1'b1), {tag, " R6 pending"}, r, ctrl_word(ch, 1'b1, ie, 1'b1));
        chk(irq == ie, {tag, " R7 irq"}, irq, ie);
        wr(2'd2, 32'd0);
        rd(2'd2, r);
        chk(r == 0 && !irq && !pwr_on, {tag, " R8 zero write"}, r, 0);
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int cyc;
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            chk(r == 0, "R1 register reset", r, 0);
        end
        chk(!irq && !pwr_on, "R1 irq and power low", {irq, pwr_on}, 0);

        // R2 register widths and readback
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, r);
        chk(r == 32'h3F, "R2 delay width", r, 32'h3F);
        wr(2'd2, 32'hFFFF_FF37);
        rd(2'd2, r);
        chk(r == 32'h27, "R2 control readback", r, 32'h27);
        rd(2'd1, r);
        chk(r == 0, "R3 no start without power", r, 0);
        wr(2'd2, 32'd0);

        // directed corners
        convert(3'd5, 1'b1, 10'h2A5, 8, "typical");
        convert(3'd7, 1'b1, 10'h3FF, 0, "fullscale d0");
        convert(3'd0, 1'b0, 10'h000, 1, "zero d1");
        convert(3'd2, 1'b1, 10'h200, 63, "mid d63");

        // R9 R10: rewrite control mid-conversion with power still 1
        vin = 10'h155;
        wr(2'd3, 32'd4);
        wr(2'd2, ctrl_word(3'd6, 1'b1, 1'b1, 1'b0));
        run(5, ctrl_word(3'd1, 1'b1, 1'b1, 1'b0), 3'd6, cyc);
        chk(cyc == busy_len(4), "R9 no restart mid-run", cyc, busy_len(4));
        chk(chan_bad == 0, "R10 mux held across rewrite", chan_bad, 0);
        chk(mux_sel == 3'd6, "R10 mux after run", mux_sel, 6);
        rd(2'd0, r);
        chk(r == 32'h155, "R5 result after rewrite", r, 32'h155);

        // R9 after completion, R11 pending write semantics
        wr(2'd2, ctrl_word(3'd1, 1'b1, 1'b1, 1'b1));
        rd(2'd1, r);
        chk(r == 0, "R9 no restart when done", r, 0);
        rd(2'd2, r);
        chk(r[6] == 1'b1 && irq, "R11 write 1 keeps pending", r[6], 1);
        wr(2'd2, ctrl_word(3'd1, 1'b1, 1'b1, 1'b0));
        rd(2'd2, r);
        chk(r == ctrl_word(3'd1, 1'b1, 1'b1, 1'b0) && !irq, "R11 write 0 clears pending", r,
            ctrl_word(3'd1, 1'b1, 1'b1, 1'b0));
        rd(2'd1, r);
        chk(r == 0, "R9 still idle", r, 0);
        wr(2'd2, 32'd0);
        wr(2'd2, 32'h40);
        rd(2'd2, r);
        chk(r == 0, "R11 write 1 cannot set pending", r, 0);

        // R8 abort mid-conversion
        vin = 10'h0F0;
        wr(2'd3, 32'd6);
        wr(2'd2, ctrl_word(3'd3, 1'b1, 1'b1, 1'b0));
        run(9, 32'd0, 3'd3, cyc);
        chk(cyc == 9, "R8 abort ends busy", cyc, 9);
        repeat (12) @(negedge clk);
        rd(2'd0, r);
        chk(r == 32'h155, "R8 result kept on abort", r, 32'h155);
        rd(2'd2, r);
        chk(r == 0 && !irq && !pwr_on, "R8 no pending after abort", r, 0);

        // constrained random
        for (int i = 0; i < 24; i++) begin
            int d;
            d = (i % 6 == 5) ? 63 : int'($urandom_range(0, 20));
            convert(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                    RES'($urandom_range(0, 1023)), d, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule